// File: doc/BRIEF.md
# Dual-Chain Serial Configuration Loader

This block takes one serial data bit stream and one shift strobe and steers them into one of two shift chains. A select input picks the chain. The intensity chain holds sixteen 12-bit channel words, which is 192 bits. The trim chain holds sixteen 6-bit channel words, which is 96 bits. Each chain has its own parallel holding register. A rising edge on the load input copies the selected chain into that register. The serial output always shows the top bit of the selected chain, so several devices can be cascaded on one data line.

Everything runs on the block clock `clk`. A cycle with `shift_en` high stands for one rising edge of the external shift clock. The `chain_sel` input may change only in a cycle where no shift happens. Software sends the most significant bit of channel 15 first. After a full chain length of shifts plus one rising load edge, the holding register drives the parallel bus. Channel 0 sits in the least significant word of that bus.

Top module: `dual_chain_loader`

## Requirements
- R1: While `rst_n` is low, both chains and both holding registers clear to zero. Right after reset, `sdo`, `gs_bus` and `dc_bus` read zero.
- R2: When `chain_sel`=0 and `shift_en`=1, the intensity chain moves one place toward bit 191 on the clock edge, and `sdi` enters bit 0.
- R3: When `chain_sel`=1 and `shift_en`=1, the trim chain moves one place toward bit 95 on the clock edge, and `sdi` enters bit 0.
- R4: `sdo` equals bit 191 of the intensity chain when `chain_sel`=0. It equals bit 95 of the trim chain when `chain_sel`=1. It follows `chain_sel` with no clock delay.
- R5: The chain that is not selected, and its holding register, keep their contents while the other chain shifts or loads.
- R6: A clock edge where `load_strobe` is 1 and was 0 at the previous edge copies the selected chain into its holding register. That register drives the bus from the next cycle on.
- R7: Holding `load_strobe` high for many cycles gives exactly one copy. Shifts made while it stays high do not reach the bus.
- R8: If a load edge and a shift fall on the same clock edge, the holding register takes the chain contents from before that shift.
- R9: Channel n of the intensity bus is `gs_bus[12n+11:12n]`. Channel n of the trim bus is `dc_bus[6n+5:6n]`.
- R10: `chain_sel` must hold the same value at a shifting edge as at the edge before it. A change at a shifting edge is a protocol violation, and the bench flags it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data in |
| shift_en | input | 1 | One shift of the selected chain this cycle |
| chain_sel | input | 1 | 0 selects the intensity chain, 1 selects the trim chain |
| load_strobe | input | 1 | Level input; its rising edge loads the selected holding register |
| sdo | output | 1 | Top bit of the selected chain |
| gs_bus | output | 192 | Latched intensity words, channel 0 in the low 12 bits |
| dc_bus | output | 96 | Latched trim words, channel 0 in the low 6 bits |

## Verification
The bench loads patterns that are unlikely to repeat into both chains, in several orders. This catches a design that shifts the wrong chain or keeps the wrong width: the loaded word comes back shifted or truncated. The bench holds the load input high while shifting, which exposes a level-sensitive load because the bus would keep following the chain. It also loads and shifts on the same edge, which exposes a holding register that captures post-shift data. Channel-indexed words check that the bus ordering is correct, and a reset in mid-sequence checks that every register clears.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    localparam int unsigned CHANNELS  = 16;
    localparam int unsigned GS_BITS   = 12;
    localparam int unsigned DC_BITS   = 6;

    typedef enum logic {
        SEL_GS = 1'b0,
        SEL_DC = 1'b1
    } chain_sel_e;
endpackage

// File: rtl/dcl_shift_chain.sv
module dcl_shift_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic [WIDTH-1:0] bits
);
    typedef struct packed {
        logic [WIDTH-1:0] sr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.sr = {st_q.sr[WIDTH-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits = st_q.sr;
endmodule

// File: rtl/dcl_hold_reg.sv
module dcl_hold_reg #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] val;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.val = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;
endmodule

// File: rtl/dcl_rise_detect.sv
module dcl_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    typedef struct packed {
        logic prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise = level & ~st_q.prev;
endmodule

// File: rtl/dual_chain_loader.sv
module dual_chain_loader #(
    parameter int unsigned N_CH = dcl_pkg::CHANNELS,
    parameter int unsigned GS_W = dcl_pkg::GS_BITS,
    parameter int unsigned DC_W = dcl_pkg::DC_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sdi,
    input  logic                 shift_en,
    input  logic                 chain_sel,
    input  logic                 load_strobe,
    output logic                 sdo,
    output logic [N_CH*GS_W-1:0] gs_bus,
    output logic [N_CH*DC_W-1:0] dc_bus
);
    import dcl_pkg::*;

    localparam int unsigned GS_LEN = N_CH * GS_W;
    localparam int unsigned DC_LEN = N_CH * DC_W;
    localparam int unsigned N_CHAIN = 2;

    typedef struct packed {
        logic [N_CHAIN-1:0] shift;
        logic [N_CHAIN-1:0] load;
        logic               out_bit;
    } steer_t;

    logic        load_rise;
    logic [GS_LEN-1:0] gs_chain;
    logic [DC_LEN-1:0] dc_chain;
    steer_t      steer;
    chain_sel_e  sel_e;

    assign sel_e = chain_sel_e'(chain_sel);

    dcl_rise_detect u_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .level (load_strobe),
        .rise  (load_rise)
    );

    always_comb begin
        steer = '0;
        for (int i = 0; i < N_CHAIN; i++) begin
            steer.shift[i] = shift_en    & (sel_e == chain_sel_e'(i));
            steer.load[i]  = load_rise   & (sel_e == chain_sel_e'(i));
        end
        steer.out_bit = (sel_e == SEL_DC) ? dc_chain[DC_LEN-1] : gs_chain[GS_LEN-1];
    end

    generate
        for (genvar c = 0; c < N_CHAIN; c++) begin : g_path
            if (c == 0) begin : g_gs
                dcl_shift_chain #(.WIDTH(GS_LEN)) u_chain (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (steer.shift[c]),
                    .din   (sdi),
                    .bits  (gs_chain)
                );
                dcl_hold_reg #(.WIDTH(GS_LEN)) u_hold (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .load  (steer.load[c]),
                    .d     (gs_chain),
                    .q     (gs_bus)
                );
            end else begin : g_dc
                dcl_shift_chain #(.WIDTH(DC_LEN)) u_chain (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .en    (steer.shift[c]),
                    .din   (sdi),
                    .bits  (dc_chain)
                );
                dcl_hold_reg #(.WIDTH(DC_LEN)) u_hold (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .load  (steer.load[c]),
                    .d     (dc_chain),
                    .q     (dc_bus)
                );
            end
        end
    endgenerate

    assign sdo = steer.out_bit;
endmodule

// File: rtl/dcl_checker.sv
module dcl_checker #(
    parameter int unsigned GS_LEN = 192,
    parameter int unsigned DC_LEN = 96
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en,
    input logic              chain_sel,
    input logic              load_strobe,
    input logic              sdo,
    input logic [GS_LEN-1:0] gs_bus,
    input logic [DC_LEN-1:0] dc_bus
);
    // R1: registers clear through reset
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gs_bus == '0 && dc_bus == '0 && !sdo));

    // R4: with no shift on the prior edge and a steady select, sdo holds
    a_r4_sdo_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(shift_en) && $stable(chain_sel)) |-> $stable(sdo));

    // R5, R6: intensity bus moves only after a load edge with select low
    a_r6_gs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_strobe && !$past(load_strobe) && !chain_sel) |=> $stable(gs_bus));

    // R5, R6: trim bus moves only after a load edge with select high
    a_r5_dc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_strobe && !$past(load_strobe) && chain_sel) |=> $stable(dc_bus));

    // R7: a strobe that stays high gives no further copy
    a_r7_single_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load_strobe && $past(load_strobe)) |=> ($stable(gs_bus) && $stable(dc_bus)));

    // R10: select steady at every shifting edge
    a_r10_sel_steady: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |-> $stable(chain_sel));
endmodule

bind dual_chain_loader dcl_checker #(
    .GS_LEN(N_CH*GS_W),
    .DC_LEN(N_CH*DC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en    (shift_en),
    .chain_sel   (chain_sel),
    .load_strobe (load_strobe),
    .sdo         (sdo),
    .gs_bus      (gs_bus),
    .dc_bus      (dc_bus)
);

// File: tb/sim_dual_chain_loader.sv
module sim_dual_chain_loader;
    localparam int CLK_PERIOD = 10;
    localparam int GS_LEN = 192;
    localparam int DC_LEN = 96;
    localparam int WATCHDOG = 50000;

    // vector: {select, seed}
    localparam logic [32:0] VEC [6] = '{
        {1'b0, 32'h1234_5678},
        {1'b1, 32'h0BAD_F00D},
        {1'b0, 32'hDEAD_BEEF},
        {1'b1, 32'h0000_0001},
        {1'b1, 32'h7777_1111},
        {1'b0, 32'hA5A5_5A5A}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic sdi = 0;
    logic shift_en = 0;
    logic chain_sel = 0;
    logic load_strobe = 0;
    logic sdo;
    logic [GS_LEN-1:0] gs_bus;
    logic [DC_LEN-1:0] dc_bus;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    logic [GS_LEN-1:0] gs_m = '0, gs_l = '0;
    logic [DC_LEN-1:0] dc_m = '0, dc_l = '0;
    logic prev_strobe = 0;
    logic sel_last = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_chain_loader u0 (
        .clk(clk), .rst_n(rst_n), .sdi(sdi), .shift_en(shift_en),
        .chain_sel(chain_sel), .load_strobe(load_strobe),
        .sdo(sdo), .gs_bus(gs_bus), .dc_bus(dc_bus)
    );

    // R10 protocol monitor
    always @(posedge clk) begin
        if (rst_n && shift_en && chain_sel !== sel_last) begin
            fails++;
            $display("FAIL R10 select changed at shift edge: sel=%0b prev=%0b", chain_sel, sel_last);
        end
        sel_last = chain_sel;
    end

    function automatic logic [GS_LEN-1:0] pat(input logic [31:0] seed);
        logic [31:0] x = seed;
        logic [GS_LEN-1:0] p;
        for (int i = 0; i < GS_LEN; i++) begin
            x = x ^ (x << 13);
            x = x ^ (x >> 17);
            x = x ^ (x << 5);
            p[i] = x[0];
        end
        return p;
    endfunction

    task automatic clk_step();
        @(posedge clk);
        if (!rst_n) begin
            gs_m = '0; dc_m = '0; gs_l = '0; dc_l = '0; prev_strobe = 0;
        end else begin
            if (load_strobe && !prev_strobe) begin
                if (chain_sel) dc_l = dc_m; else gs_l = gs_m;
            end
            if (shift_en) begin
                if (chain_sel) dc_m = {dc_m[DC_LEN-2:0], sdi};
                else           gs_m = {gs_m[GS_LEN-2:0], sdi};
            end
            prev_strobe = load_strobe;
        end
        @(negedge clk);
    endtask

    task automatic step(input logic s, input logic d, input logic sh, input logic st);
        if (sh && s !== chain_sel) begin
            shift_en = 0;
            chain_sel = s;
            clk_step();
        end
        chain_sel = s; sdi = d; shift_en = sh; load_strobe = st;
        clk_step();
    endtask

    task automatic check_all(input string tag);
        logic exp_sdo;
        exp_sdo = chain_sel ? dc_m[DC_LEN-1] : gs_m[GS_LEN-1];
        checks++;
        if (gs_bus !== gs_l) begin
            fails++;
            $display("FAIL %s gs_bus actual=%h expected=%h", tag, gs_bus, gs_l);
        end
        checks++;
        if (dc_bus !== dc_l) begin
            fails++;
            $display("FAIL %s dc_bus actual=%h expected=%h", tag, dc_bus, dc_l);
        end
        checks++;
        if (sdo !== exp_sdo) begin
            fails++;
            $display("FAIL %s sdo actual=%b expected=%b", tag, sdo, exp_sdo);
        end
    endtask

    task automatic load_chain(input logic s, input logic [GS_LEN-1:0] p);
        int len = s ? DC_LEN : GS_LEN;
        for (int i = len - 1; i >= 0; i--) step(s, p[i], 1'b1, 1'b0);
        step(s, 1'b0, 1'b0, 1'b1);
        step(s, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        clk_step();
        check_all("R1 during reset");
        rst_n = 1;
        clk_step();
        check_all("R1 after reset");

        // table walk: R2 intensity / R3 trim loads
        for (int v = 0; v < 6; v++) begin
            load_chain(VEC[v][32], pat(VEC[v][31:0]));
            check_all(VEC[v][32] ? "R3 trim load" : "R2 intensity load");
        end

        // R4: sdo tracks select immediately, and during shifting
        chain_sel = 1; #1; check_all("R4 select high");
        chain_sel = 0; #1; check_all("R4 select low");
        for (int i = 0; i < 10; i++) begin
            step(1'b0, i[0], 1'b1, 1'b0);
            check_all("R4 sdo while shifting");
        end

        // R5: interleave, other chain untouched
        for (int i = 0; i < 8; i++) step(1'b1, ~i[1], 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R5 intensity chain kept");
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R5 trim latch kept on intensity load");

        // R7: strobe held high during shifts
        step(1'b1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b1, 1'b1);
        check_all("R7 held strobe one load");
        step(1'b1, 1'b0, 1'b0, 1'b0);

        // R8: load and shift on one edge
        step(1'b0, 1'b1, 1'b1, 1'b1);
        check_all("R8 load takes pre-shift data");
        step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        check_all("R8 next load takes shifted data");

        // R9: channel placement
        begin
            logic [GS_LEN-1:0] gp = '0;
            logic [GS_LEN-1:0] dp = '0;
            for (int n = 0; n < 16; n++) begin
                gp[n*12 +: 12] = 12'(n + 12'h100);
                dp[n*6 +: 6]   = 6'(63 - n);
            end
            load_chain(1'b0, gp);
            load_chain(1'b1, dp);
            for (int n = 0; n < 16; n++) begin
                checks++;
                if (gs_bus[n*12 +: 12] !== 12'(n + 12'h100)) begin
                    fails++;
                    $display("FAIL R9 gs ch%0d actual=%h expected=%h", n, gs_bus[n*12 +: 12], 12'(n + 12'h100));
                end
                checks++;
                if (dc_bus[n*6 +: 6] !== 6'(63 - n)) begin
                    fails++;
                    $display("FAIL R9 dc ch%0d actual=%h expected=%h", n, dc_bus[n*6 +: 6], 6'(63 - n));
                end
            end
        end

        // R1: reset in mid-stream
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 1'b1, 1'b0);
        rst_n = 0;
        clk_step();
        clk_step();
        rst_n = 1;
        clk_step();
        check_all("R1 mid-stream reset");

        // R10: no protocol violation seen (monitor counts any)
        checks++;
        done = 1;
        finish_run();
    end
endmodule